// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps track of cache misses that are waiting for memory, so the cache can go on serving hits to other lines while those misses are pending. Each incoming miss carries a line address and a requester ID. It is compared against every valid entry. A miss to a line that is already pending is recorded in that entry as an extra target and sends nothing to memory. A miss to a new line takes a free entry and sends a memory request in the same cycle. The request is tagged with the index of the entry.

When memory returns a fill with an entry tag, the block reports all requester IDs waiting on that line in the same cycle and frees the entry at the next clock edge. The stall output tells the pipeline to hold its miss. It is raised only when the miss needs a new entry and every entry is in use, or when the matching entry has no target slot left. A miss that arrives in the same cycle as the fill for its own line is flagged as satisfied by that fill. The number of entries is a parameter, sized to suit the memory bus bandwidth.

Top module: `mshr_file`

## Requirements
- R1: After an asynchronous reset (rst_ni low), or after reset is released, no entry is valid, and stall_o, bypass_o, req_valid_o and done_valid_o are low. A fill to a tag that was allocated before the reset reports nothing.
- R2: A miss to a line that no valid entry holds, while some entry is free, raises req_valid_o in the same cycle. req_line_o equals the miss line and req_tag_o is the lowest free entry index.
- R3: A miss whose line matches a valid entry that holds fewer than MAX_TGT targets merges into that entry. It issues no request and no stall. Its requester ID is stored in the next target slot, where slot k occupies bits [k*ID_W +: ID_W] of the report.
- R4: An entry holds at most MAX_TGT (default 4) targets. A further miss to that line raises stall_o, and its ID does not appear in the later report.
- R5: stall_o is high only when miss_valid_i is high and either the line is new with all N_ENTRIES entries valid, or the matching entry is full of targets. A merge into a pending line still proceeds when every entry is in use.
- R6: A fill whose tag names a valid entry raises done_valid_o in the same cycle. done_cnt_o gives the target count and done_rids_o the stored IDs, with unused slots zero. The entry becomes free at the next edge and can be allocated again. While done_valid_o is low, done_cnt_o and done_rids_o are zero.
- R7: A miss whose line matches the entry being filled in the same cycle raises bypass_o. It causes no allocation, no merge and no stall.
- R8: The block works with N_ENTRIES of 2 and of 4. With 2 entries, a third distinct pending line stalls until a fill frees an entry.
- R9: No two valid entries ever hold the same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | A cache miss is presented |
| miss_line_i | input | LINE_W | Line address of the miss |
| miss_rid_i | input | ID_W | Requester ID of the miss |
| stall_o | output | 1 | Miss cannot be taken this cycle; hold it |
| bypass_o | output | 1 | Miss is satisfied by the fill arriving this cycle |
| req_valid_o | output | 1 | Memory request issued |
| req_line_o | output | LINE_W | Line address requested (zero when idle) |
| req_tag_o | output | TAG_W | Entry index carried by the request |
| fill_valid_i | input | 1 | Fill data returning from memory |
| fill_tag_i | input | TAG_W | Entry index of the returning fill |
| done_valid_o | output | 1 | Targets of a filled entry are reported |
| done_cnt_o | output | CNT_W | Number of waiting targets |
| done_rids_o | output | MAX_TGT*ID_W | Waiting requester IDs, slot 0 in the low bits |

## Verification
The bench builds one instance with four entries, four targets per entry and 16-bit lines. With that instance it can fill every entry, run a target list to its limit, and hit both stall causes in one walk. A second instance with two entries shows the smaller configuration filling up after only two distinct lines and recovering after a fill. Using four targets per entry keeps the slot-overflow case a few cycles away, and the 16-bit lines keep the expected values readable.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [2:0] {
    MO_IDLE,
    MO_ALLOC,
    MO_MERGE,
    MO_BYPASS,
    MO_STALL
  } miss_op_e;
endpackage

// File: rtl/mshr_entry.sv
module mshr_entry #(
  parameter int LINE_W  = 26,
  parameter int ID_W    = 4,
  parameter int MAX_TGT = 4,
  localparam int CNT_W  = $clog2(MAX_TGT + 1),
  localparam int RID_W  = MAX_TGT * ID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic              merge_i,
  input  logic              free_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [ID_W-1:0]   rid_i,
  output logic              valid_o,
  output logic [LINE_W-1:0] line_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [RID_W-1:0]  rids_o
);
  logic              valid_q;
  logic [LINE_W-1:0] line_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [RID_W-1:0]  rids_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      line_q  <= '0;
      cnt_q   <= '0;
      rids_q  <= '0;
    end else if (free_i) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
      rids_q  <= '0;
    end else if (alloc_i) begin
      valid_q            <= 1'b1;
      line_q             <= line_i;
      cnt_q              <= CNT_W'(1);
      rids_q             <= '0;
      rids_q[ID_W-1:0]   <= rid_i;
    end else if (merge_i) begin
      for (int k = 0; k < MAX_TGT; k++) begin
        if (cnt_q == CNT_W'(k)) rids_q[k*ID_W +: ID_W] <= rid_i;
      end
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign valid_o = valid_q;
  assign line_o  = line_q;
  assign cnt_o   = cnt_q;
  assign rids_o  = rids_q;
endmodule

// File: rtl/mshr_match.sv
module mshr_match #(
  parameter int N_ENTRIES = 4,
  parameter int LINE_W    = 26,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic [N_ENTRIES-1:0]        valid_i,
  input  logic [N_ENTRIES*LINE_W-1:0] lines_i,
  input  logic [LINE_W-1:0]           line_i,
  output logic                        hit_o,
  output logic [IDX_W-1:0]            idx_o
);
  logic [N_ENTRIES-1:0] hit_vec;

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = valid_i[i] && (lines_i[i*LINE_W +: LINE_W] == line_i);
  end

  // at most one entry matches, so OR-ing indices encodes it
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (hit_vec[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/mshr_alloc.sv
module mshr_alloc #(
  parameter int N_ENTRIES = 4,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic [N_ENTRIES-1:0] valid_i,
  output logic                 free_o,
  output logic [IDX_W-1:0]     idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign free_o = ~&valid_i;
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int LINE_W    = 26,
  parameter int ID_W      = 4,
  parameter int MAX_TGT   = 4,
  localparam int TAG_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int CNT_W    = $clog2(MAX_TGT + 1),
  localparam int RID_W    = MAX_TGT * ID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  input  logic [LINE_W-1:0] miss_line_i,
  input  logic [ID_W-1:0]   miss_rid_i,
  output logic              stall_o,
  output logic              bypass_o,
  output logic              req_valid_o,
  output logic [LINE_W-1:0] req_line_o,
  output logic [TAG_W-1:0]  req_tag_o,
  input  logic              fill_valid_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  output logic              done_valid_o,
  output logic [CNT_W-1:0]  done_cnt_o,
  output logic [RID_W-1:0]  done_rids_o
);
  logic [N_ENTRIES-1:0]        valid_q;
  logic [N_ENTRIES*LINE_W-1:0] line_flat;
  logic [CNT_W-1:0]            cnt_q  [N_ENTRIES];
  logic [RID_W-1:0]            rids_q [N_ENTRIES];
  logic [N_ENTRIES-1:0]        alloc_v, merge_v, free_v;

  logic             hit_any, free_any, fill_hit;
  logic [TAG_W-1:0] hit_idx, free_idx;
  miss_op_e         op;

  mshr_match #(.N_ENTRIES(N_ENTRIES), .LINE_W(LINE_W)) u_match (
    .valid_i (valid_q),
    .lines_i (line_flat),
    .line_i  (miss_line_i),
    .hit_o   (hit_any),
    .idx_o   (hit_idx)
  );

  mshr_alloc #(.N_ENTRIES(N_ENTRIES)) u_alloc (
    .valid_i (valid_q),
    .free_o  (free_any),
    .idx_o   (free_idx)
  );

  assign fill_hit = fill_valid_i && (int'(fill_tag_i) < N_ENTRIES) && valid_q[fill_tag_i];

  always_comb begin
    op = MO_IDLE;
    if (miss_valid_i) begin
      if (hit_any) begin
        if (fill_hit && (fill_tag_i == hit_idx))         op = MO_BYPASS;
        else if (cnt_q[hit_idx] == CNT_W'(MAX_TGT))      op = MO_STALL;
        else                                             op = MO_MERGE;
      end else if (free_any) begin
        op = MO_ALLOC;
      end else begin
        op = MO_STALL;
      end
    end
  end

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    assign alloc_v[i] = (op == MO_ALLOC) && (free_idx == TAG_W'(i));
    assign merge_v[i] = (op == MO_MERGE) && (hit_idx == TAG_W'(i));
    assign free_v[i]  = fill_hit && (fill_tag_i == TAG_W'(i));

    mshr_entry #(.LINE_W(LINE_W), .ID_W(ID_W), .MAX_TGT(MAX_TGT)) u_entry (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .alloc_i (alloc_v[i]),
      .merge_i (merge_v[i]),
      .free_i  (free_v[i]),
      .line_i  (miss_line_i),
      .rid_i   (miss_rid_i),
      .valid_o (valid_q[i]),
      .line_o  (line_flat[i*LINE_W +: LINE_W]),
      .cnt_o   (cnt_q[i]),
      .rids_o  (rids_q[i])
    );
  end

  assign stall_o      = (op == MO_STALL);
  assign bypass_o     = (op == MO_BYPASS);
  assign req_valid_o  = (op == MO_ALLOC);
  assign req_line_o   = req_valid_o ? miss_line_i : '0;
  assign req_tag_o    = req_valid_o ? free_idx : '0;
  assign done_valid_o = fill_hit;
  assign done_cnt_o   = fill_hit ? cnt_q[fill_tag_i] : '0;
  assign done_rids_o  = fill_hit ? rids_q[fill_tag_i] : '0;
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
  parameter int N_ENTRIES = 4,
  parameter int LINE_W    = 26,
  localparam int TAG_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        miss_valid_i,
  input logic                        stall_o,
  input logic                        bypass_o,
  input logic                        req_valid_o,
  input logic [LINE_W-1:0]           req_line_o,
  input logic [TAG_W-1:0]            req_tag_o,
  input logic                        done_valid_o,
  input logic [TAG_W-1:0]            fill_tag_i,
  input logic [N_ENTRIES-1:0]        valid_q,
  input logic [N_ENTRIES*LINE_W-1:0] line_flat
);
  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (valid_q[i] && (line_flat[i*LINE_W +: LINE_W] == req_line_o)) dup = 1'b1;
    end
  end

  a_r2_alloc_from_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !valid_q[req_tag_o]);

  a_r2_alloc_sets_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> valid_q[$past(req_tag_o)]);

  a_r5_stall_needs_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> miss_valid_i);

  a_r6_fill_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o |=> !valid_q[$past(fill_tag_i)]);

  a_r7_bypass_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_o |-> (!req_valid_o && !stall_o && done_valid_o));

  a_r9_unique_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !dup);
endmodule

bind mshr_file mshr_file_chk #(.N_ENTRIES(N_ENTRIES), .LINE_W(LINE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .miss_valid_i (miss_valid_i),
  .stall_o      (stall_o),
  .bypass_o     (bypass_o),
  .req_valid_o  (req_valid_o),
  .req_line_o   (req_line_o),
  .req_tag_o    (req_tag_o),
  .done_valid_o (done_valid_o),
  .fill_tag_i   (fill_tag_i),
  .valid_q      (valid_q),
  .line_flat    (line_flat)
);

// File: tb/mshr_file_test.sv
module mshr_file_test;
  localparam int PERIOD = 10;

  typedef struct packed {
    logic [3:0]  rq;
    logic        mv;
    logic [15:0] line;
    logic [3:0]  rid;
    logic        fv;
    logic [1:0]  ftag;
    logic        e_stall;
    logic        e_req;
    logic [1:0]  e_tag;
    logic        e_done;
    logic [2:0]  e_cnt;
    logic [15:0] e_rids;
    logic        e_byp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 1'b1, 16'h0100, 4'd1,  1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0, 3'd0, 16'h0000, 1'b0}, // R2 line A
    '{4'd2, 1'b1, 16'h0200, 4'd2,  1'b0, 2'd0, 1'b0, 1'b1, 2'd1, 1'b0, 3'd0, 16'h0000, 1'b0}, // R2 line B
    '{4'd3, 1'b1, 16'h0100, 4'd3,  1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 16'h0000, 1'b0}, // R3 merge
    '{4'd3, 1'b1, 16'h0100, 4'd4,  1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 16'h0000, 1'b0}, // R3
    '{4'd3, 1'b1, 16'h0100, 4'd5,  1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 16'h0000, 1'b0}, // R3 fourth target
    '{4'd4, 1'b1, 16'h0100, 4'd6,  1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 3'd0, 16'h0000, 1'b0}, // R4 fifth target stalls
    '{4'd6, 1'b0, 16'h0000, 4'd0,  1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 3'd4, 16'h5431, 1'b0}, // R6 report A
    '{4'd6, 1'b1, 16'h0300, 4'd7,  1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0, 3'd0, 16'h0000, 1'b0}, // R6 reuse slot 0
    '{4'd2, 1'b1, 16'h0400, 4'd8,  1'b0, 2'd0, 1'b0, 1'b1, 2'd2, 1'b0, 3'd0, 16'h0000, 1'b0}, // R2
    '{4'd2, 1'b1, 16'h0500, 4'd9,  1'b0, 2'd0, 1'b0, 1'b1, 2'd3, 1'b0, 3'd0, 16'h0000, 1'b0}, // R2
    '{4'd5, 1'b1, 16'h0600, 4'd10, 1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 3'd0, 16'h0000, 1'b0}, // R5 full
    '{4'd7, 1'b1, 16'h0200, 4'd11, 1'b1, 2'd1, 1'b0, 1'b0, 2'd0, 1'b1, 3'd1, 16'h0002, 1'b1}, // R7 bypass
    '{4'd5, 1'b1, 16'h0600, 4'd10, 1'b0, 2'd0, 1'b0, 1'b1, 2'd1, 1'b0, 3'd0, 16'h0000, 1'b0}, // R5 retry
    '{4'd5, 1'b1, 16'h0300, 4'd12, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 16'h0000, 1'b0}, // R5 merge when full
    '{4'd6, 1'b0, 16'h0000, 4'd0,  1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 3'd2, 16'h00C7, 1'b0}, // R6 report C
    '{4'd5, 1'b0, 16'h0000, 4'd0,  1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 16'h0000, 1'b0}  // R5 idle
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_v = 1'b0;
  logic [15:0] miss_line = '0;
  logic [3:0]  miss_rid = '0;
  logic        fill_v = 1'b0;
  logic [1:0]  fill_tag = '0;
  logic        stall, byp, req_v, done_v;
  logic [15:0] req_line, done_rids;
  logic [1:0]  req_tag;
  logic [2:0]  done_cnt;

  logic        b_miss_v = 1'b0;
  logic [15:0] b_miss_line = '0;
  logic        b_fill_v = 1'b0;
  logic        b_fill_tag = 1'b0;
  logic        b_stall, b_byp, b_req_v, b_done_v, b_req_tag;
  logic [15:0] b_req_line, b_done_rids;
  logic [2:0]  b_done_cnt;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  mshr_file #(.N_ENTRIES(4), .LINE_W(16), .ID_W(4), .MAX_TGT(4)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .miss_valid_i(miss_v), .miss_line_i(miss_line), .miss_rid_i(miss_rid),
    .stall_o(stall), .bypass_o(byp),
    .req_valid_o(req_v), .req_line_o(req_line), .req_tag_o(req_tag),
    .fill_valid_i(fill_v), .fill_tag_i(fill_tag),
    .done_valid_o(done_v), .done_cnt_o(done_cnt), .done_rids_o(done_rids)
  );

  mshr_file #(.N_ENTRIES(2), .LINE_W(16), .ID_W(4), .MAX_TGT(4)) uut_two (
    .clk_i(clk), .rst_ni(rst_n),
    .miss_valid_i(b_miss_v), .miss_line_i(b_miss_line), .miss_rid_i(4'd1),
    .stall_o(b_stall), .bypass_o(b_byp),
    .req_valid_o(b_req_v), .req_line_o(b_req_line), .req_tag_o(b_req_tag),
    .fill_valid_i(b_fill_v), .fill_tag_i(b_fill_tag),
    .done_valid_o(b_done_v), .done_cnt_o(b_done_cnt), .done_rids_o(b_done_rids)
  );

  task automatic check(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input logic mv, input logic [15:0] ln, input logic [3:0] rid,
                       input logic fv, input logic [1:0] ft);
    @(negedge clk);
    miss_v = mv; miss_line = ln; miss_rid = rid; fill_v = fv; fill_tag = ft;
    #(PERIOD/4);
  endtask

  task automatic drive_b(input logic mv, input logic [15:0] ln, input logic fv, input logic ft);
    @(negedge clk);
    b_miss_v = mv; b_miss_line = ln; b_fill_v = fv; b_fill_tag = ft;
    #(PERIOD/4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    drive(1'b0, '0, '0, 1'b0, '0);
    check(1, "stall after reset", 32'(stall), 32'd0);
    check(1, "req after reset",   32'(req_v), 32'd0);
    check(1, "done after reset",  32'(done_v), 32'd0);
    check(1, "bypass after reset", 32'(byp), 32'd0);

    for (int v = 0; v < NV; v++) begin
      drive(VECS[v].mv, VECS[v].line, VECS[v].rid, VECS[v].fv, VECS[v].ftag);
      check(int'(VECS[v].rq), $sformatf("v%0d stall", v), 32'(stall), 32'(VECS[v].e_stall));
      check(int'(VECS[v].rq), $sformatf("v%0d req", v), 32'(req_v), 32'(VECS[v].e_req));
      check(int'(VECS[v].rq), $sformatf("v%0d tag", v), 32'(req_tag), 32'(VECS[v].e_tag));
      check(int'(VECS[v].rq), $sformatf("v%0d req_line", v), 32'(req_line),
            VECS[v].e_req ? 32'(VECS[v].line) : 32'd0);
      check(int'(VECS[v].rq), $sformatf("v%0d done", v), 32'(done_v), 32'(VECS[v].e_done));
      check(int'(VECS[v].rq), $sformatf("v%0d cnt", v), 32'(done_cnt), 32'(VECS[v].e_cnt));
      check(int'(VECS[v].rq), $sformatf("v%0d rids", v), 32'(done_rids), 32'(VECS[v].e_rids));
      check(int'(VECS[v].rq), $sformatf("v%0d bypass", v), 32'(byp), 32'(VECS[v].e_byp));
    end

    // R1 reset mid-run: entries 1..3 valid, slot 0 free -> 0x0700 takes tag 0
    drive(1'b1, 16'h0700, 4'd3, 1'b0, 2'd0);
    check(1, "pre-reset alloc tag", 32'(req_tag), 32'd0);
    @(negedge clk);
    miss_v = 1'b0;
    rst_n = 1'b0;
    #(PERIOD/4);
    check(1, "req during reset", 32'(req_v), 32'd0);
    @(negedge clk) rst_n = 1'b1;
    drive(1'b0, '0, '0, 1'b1, 2'd0);
    check(1, "fill after reset reports nothing", 32'(done_v), 32'd0);
    drive(1'b1, 16'h0200, 4'd1, 1'b0, 2'd0);
    check(1, "old line re-requested after reset", 32'(req_v), 32'd1);
    check(1, "lowest tag after reset", 32'(req_tag), 32'd0);
    drive(1'b0, '0, '0, 1'b0, '0);

    // R8 two-entry configuration
    drive_b(1'b1, 16'h0010, 1'b0, 1'b0);
    check(8, "two: first tag", {31'd0, b_req_v, b_req_tag} , 32'd2);
    drive_b(1'b1, 16'h0020, 1'b0, 1'b0);
    check(8, "two: second tag", {31'd0, b_req_v, b_req_tag}, 32'd3);
    drive_b(1'b1, 16'h0030, 1'b0, 1'b0);
    check(8, "two: third stalls", 32'(b_stall), 32'd1);
    check(8, "two: no req when full", 32'(b_req_v), 32'd0);
    drive_b(1'b0, 16'h0000, 1'b1, 1'b0);
    check(8, "two: fill reports", 32'(b_done_v), 32'd1);
    check(8, "two: fill count", 32'(b_done_cnt), 32'd1);
    drive_b(1'b1, 16'h0030, 1'b0, 1'b0);
    check(8, "two: retry allocates", {31'd0, b_req_v, b_req_tag}, 32'd2);
    check(8, "two: retry no stall", 32'(b_stall), 32'd0);
    drive_b(1'b0, 16'h0000, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule